// File: doc/BRIEF.md
# Dual-Input Serial Flash Page Program Engine

This block is the device-side command logic of a serial flash for one command: a page program whose data phase uses two data lines. While chip select is low, the host shifts in an opcode and a 24-bit address on the first data line. Each data byte then follows at two bits per serial clock, using both lines. Incoming bytes land in a page-sized buffer that marks which offsets were written. The write pointer starts at the low address byte and wraps inside the page, so only the most recent page-worth of bytes survives.

When chip select rises, the block decides whether to commit. It commits only if all of these hold: the rise falls exactly on a byte boundary, at least one byte arrived, the write-enable latch was set when the opcode was decoded, and the page lies outside the protected region. On a commit it runs a self-timed program cycle of a parameterised length. During that cycle it sweeps the buffer and issues one write strobe to a simple array write port for each marked offset. It reports busy and the write-enable latch on two status outputs.

The serial pins are sampled by the block's own system clock, so the serial clock must run several times slower than that clock. The write-enable latch is set from outside through a one-cycle set pulse.

Top module: `dual_page_prog`

## Requirements
- R1: After reset, `wip`, `wel` and `arr_we` are all 0.
- R2: The opcode (0xA2) and the 24-bit address go most significant bit first on `dq0`, one bit per rising `sck` edge while `cs_n` is low. Each data byte then takes four rising edges, most significant pair first, and in each pair `dq1` carries the higher bit.
- R3: The first data byte goes to the offset given by address bits 7:0. Each later byte goes to the next offset, and after offset 255 the pointer wraps to offset 0 of the same page.
- R4: When more than 256 data bytes are sent, each offset holds the last byte written to it, so only the last 256 bytes are programmed.
- R5: During the program cycle, one `arr_we` strobe is issued per written offset, in ascending offset order. The strobe for offset k appears in the (k+1)-th clock of the cycle, with `arr_addr` = {page, k}. Offsets that received no byte get no strobe.
- R6: A commit happens only if `cs_n` rises after a whole number of data bytes, and at least one of them. A rise anywhere else discards the command, and no strobe is issued.
- R7: `wip` goes to 1 in the clock after the valid `cs_n` rise is sampled. It stays 1 for exactly `TPP_CYCLES` clocks.
- R8: `wel` clears during the program cycle: it reads 0 from the 258th cycle clock onward, while `wip` is still 1.
- R9: The frame is ignored if `wel` is 0 when the eighth opcode bit is sampled. It is also ignored if the opcode is not 0xA2.
- R10: A nonzero `bp_level` value n protects the pages whose top (7-n) page-index bits are all ones; n = 7 protects every page. A command aimed at a protected page is discarded.
- R11: A frame whose `cs_n` falling edge occurs while `wip` is 1 is ignored in full, even if it is complete and valid.
- R12: A `wel_set` pulse sets `wel` on the next clock at any time. A discarded or ignored command leaves `wel` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples every serial pin |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sck | input | 1 | Serial clock, data sampled on its rising edge |
| dq0 | input | 1 | Serial line 0: opcode, address, low bit of each data pair |
| dq1 | input | 1 | Serial line 1: high bit of each data pair |
| wel_set | input | 1 | One-cycle pulse that sets the write-enable latch |
| bp_level | input | 3 | Block protection level |
| wip | output | 1 | Program cycle in progress |
| wel | output | 1 | Write-enable latch |
| arr_we | output | 1 | Array write strobe |
| arr_addr | output | 24 | Array byte address for the strobe |
| arr_wdata | output | 8 | Array byte data for the strobe |

## Verification
The bench goes after the page wrap and the overlong burst. A pointer that carried into the next page, or kept the first bytes instead of the last, would strobe wrong addresses or wrong data. It raises chip select one pair short of a byte and with zero data bytes; a design that committed on any rise would program a partial or empty page. It also tests a protected page, a missing write-enable latch, a wrong opcode, and a valid frame sent while busy. A design that let any of these through would raise busy and strobe the array, or would clear the latch when it should not. The busy length and the cycle in which the latch clears are compared every clock, so an off-by-one in the cycle counter shows at once.

// File: rtl/dpp_pkg.sv
// Package: shared types and constants for the dual-input page program engine.
// Assumes: nothing beyond IEEE 1800-2017.
package dpp_pkg;

    // Command sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_SKIP,
        ST_PROG
    } dpp_state_e;

    // Opcode of the dual-input page program command
    localparam logic [7:0] OPC_DUAL_PROG = 8'hA2;

endpackage

// File: rtl/dpp_edge.sv
// Module: dpp_edge
// Detects serial clock rises (while selected) and chip select edges by
// comparing each pin with its value one system clock earlier.
// Assumes: pins are synchronous to clk and sck runs several times slower.
module dpp_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    output logic sck_rise,
    output logic cs_fall,
    output logic cs_rise
);

    logic sck_q;
    logic cs_q;

    // Hold last sampled pin values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= sck;
            cs_q  <= cs_n;
        end
    end

    // Edge strobes for the current cycle
    always_comb begin
        sck_rise = sck & ~sck_q & ~cs_n;
        cs_fall  = cs_q & ~cs_n;
        cs_rise  = ~cs_q & cs_n;
    end

endmodule

// File: rtl/dpp_page_buf.sv
// Module: dpp_page_buf
// Page-sized byte store with one written flag per offset. Flags clear
// together on clr; data is not reset.
// Assumes: clr and we are never asserted in the same cycle.
module dpp_page_buf #(
    parameter int OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             we,
    input  logic [OFF_W-1:0] waddr,
    input  logic [7:0]       wdata,
    input  logic [OFF_W-1:0] raddr,
    output logic [7:0]       rdata,
    output logic             rflag
);

    localparam int DEPTH = 1 << OFF_W;

    logic [7:0]       mem [DEPTH];
    logic [DEPTH-1:0] flags;

    // Byte storage write port
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Written flags: cleared per command, set per stored byte
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            flags <= '0;
        end else if (we) begin
            flags[waddr] <= 1'b1;
        end
    end

    // Asynchronous read for the commit sweep
    always_comb begin
        rdata = mem[raddr];
        rflag = flags[raddr];
    end

endmodule

// File: rtl/dpp_protect.sv
// Module: dpp_protect
// Flags a page as protected when it lies in the top fraction of the array
// chosen by the protection level: level n protects 1/2^(max-n) of the pages.
// Assumes: (2^BP_W - 2) <= PAGE_W.
module dpp_protect #(
    parameter int PAGE_W = 16,
    parameter int BP_W   = 3
) (
    input  logic [BP_W-1:0]   bp_level,
    input  logic [PAGE_W-1:0] page,
    output logic              prot
);

    localparam int BP_MAX = (1 << BP_W) - 1;

    logic [PAGE_W:0] span;
    logic [PAGE_W:0] first_prot;

    // Protected page count and the first protected page index
    always_comb begin
        span       = (PAGE_W+1)'(1) << PAGE_W;
        first_prot = span - (span >> (BP_MAX - int'(bp_level)));
        prot       = (bp_level != '0) && ({1'b0, page} >= first_prot);
    end

endmodule

// File: rtl/dual_page_prog.sv
// Module: dual_page_prog (top)
// Accepts the dual-input page program command: opcode and address on dq0,
// data two bits per clock on dq1/dq0, buffers a page with wrap, and on a
// valid chip select rise runs a self-timed program cycle that strobes each
// written byte into the array port.
// Assumes: TPP_CYCLES > 2^OFF_W + 2; pins synchronous to clk.
module dual_page_prog #(
    parameter int ADDR_W     = 24,
    parameter int OFF_W      = 8,
    parameter int BP_W       = 3,
    parameter int TPP_CYCLES = 600
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              dq0,
    input  logic              dq1,
    input  logic              wel_set,
    input  logic [BP_W-1:0]   bp_level,
    output logic              wip,
    output logic              wel,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [7:0]        arr_wdata
);

    import dpp_pkg::*;

    localparam int PAGE_W = ADDR_W - OFF_W;
    localparam int DEPTH  = 1 << OFF_W;
    localparam int BIT_W  = $clog2(ADDR_W);
    localparam int CNT_W  = $clog2(TPP_CYCLES) + 1;

    dpp_state_e        state;
    logic [BIT_W-1:0]  bit_cnt;
    logic [ADDR_W-1:0] sr;
    logic [PAGE_W-1:0] page;
    logic [OFF_W-1:0]  ptr;
    logic [1:0]        pair_cnt;
    logic              got_byte;
    logic [CNT_W-1:0]  prog_cnt;
    logic              wel_q;

    logic              sck_rise;
    logic              cs_fall;
    logic              cs_rise;
    logic              prot;
    logic [ADDR_W-1:0] sr_next1;
    logic [7:0]        byte_next;
    logic              buf_we;
    logic              buf_clr;
    logic [7:0]        buf_rdata;
    logic              buf_rflag;
    logic              wel_clr;

    dpp_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .sck      (sck),
        .cs_n     (cs_n),
        .sck_rise (sck_rise),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise)
    );

    dpp_protect #(
        .PAGE_W (PAGE_W),
        .BP_W   (BP_W)
    ) u_protect (
        .bp_level (bp_level),
        .page     (page),
        .prot     (prot)
    );

    dpp_page_buf #(
        .OFF_W (OFF_W)
    ) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (buf_clr),
        .we    (buf_we),
        .waddr (ptr),
        .wdata (byte_next),
        .raddr (prog_cnt[OFF_W-1:0]),
        .rdata (buf_rdata),
        .rflag (buf_rflag)
    );

    // Shift candidates and buffer control
    always_comb begin
        sr_next1  = {sr[ADDR_W-2:0], dq0};
        byte_next = {sr[5:0], dq1, dq0};
        buf_clr   = (state == ST_IDLE) && cs_fall;
        buf_we    = (state == ST_DATA) && sck_rise && !cs_rise && (pair_cnt == 2'd3);
        wel_clr   = (state == ST_PROG) && (prog_cnt == CNT_W'(DEPTH));
    end

    // Command sequencer: opcode, address, data phase and program cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            sr       <= '0;
            page     <= '0;
            ptr      <= '0;
            pair_cnt <= '0;
            got_byte <= 1'b0;
            prog_cnt <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (cs_fall) begin
                        state   <= ST_OPC;
                        bit_cnt <= '0;
                    end
                end
                ST_OPC: begin
                    if (cs_rise) begin
                        state <= ST_IDLE;
                    end else if (sck_rise) begin
                        sr      <= sr_next1;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BIT_W'(7)) begin
                            bit_cnt <= '0;
                            state   <= (sr_next1[7:0] == OPC_DUAL_PROG && wel_q) ? ST_ADDR : ST_SKIP;
                        end
                    end
                end
                ST_ADDR: begin
                    if (cs_rise) begin
                        state <= ST_IDLE;
                    end else if (sck_rise) begin
                        sr      <= sr_next1;
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == BIT_W'(ADDR_W-1)) begin
                            page     <= sr_next1[ADDR_W-1:OFF_W];
                            ptr      <= sr_next1[OFF_W-1:0];
                            pair_cnt <= '0;
                            got_byte <= 1'b0;
                            state    <= ST_DATA;
                        end
                    end
                end
                ST_DATA: begin
                    if (cs_rise) begin
                        prog_cnt <= '0;
                        state    <= (got_byte && pair_cnt == 2'd0 && !prot) ? ST_PROG : ST_IDLE;
                    end else if (sck_rise) begin
                        sr       <= {sr[ADDR_W-3:0], dq1, dq0};
                        pair_cnt <= pair_cnt + 1'b1;
                        if (pair_cnt == 2'd3) begin
                            ptr      <= ptr + 1'b1;
                            got_byte <= 1'b1;
                        end
                    end
                end
                ST_SKIP: begin
                    if (cs_rise) begin
                        state <= ST_IDLE;
                    end
                end
                ST_PROG: begin
                    prog_cnt <= prog_cnt + 1'b1;
                    if (prog_cnt == CNT_W'(TPP_CYCLES-1)) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Write-enable latch: set pulse wins over the in-cycle clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel_q <= 1'b0;
        end else if (wel_set) begin
            wel_q <= 1'b1;
        end else if (wel_clr) begin
            wel_q <= 1'b0;
        end
    end

    // Status and array write port
    always_comb begin
        wip       = (state == ST_PROG);
        wel       = wel_q;
        arr_we    = wip && (prog_cnt < CNT_W'(DEPTH)) && buf_rflag;
        arr_addr  = {page, prog_cnt[OFF_W-1:0]};
        arr_wdata = buf_rdata;
    end

endmodule

// File: rtl/dpp_checker.sv
// Module: dpp_checker
// Temporal checks on the port behaviour of dual_page_prog, bound to it.
// Assumes: TPP_CYCLES > 2^OFF_W + 2 as required by the top.
module dpp_checker #(
    parameter int ADDR_W     = 24,
    parameter int OFF_W      = 8,
    parameter int TPP_CYCLES = 600
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              wip,
    input logic              wel,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr
);

    int busy_len;

    // Length of the current busy run
    always_ff @(posedge clk) begin
        if (!rst_n || !wip) begin
            busy_len <= 0;
        end else begin
            busy_len <= busy_len + 1;
        end
    end

    assert_we_in_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> wip);

    assert_strobe_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])) &&
            (arr_addr[OFF_W-1:0] > $past(arr_addr[OFF_W-1:0])));

    assert_start_on_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> ($past(cs_n) && !$past(cs_n, 2)));

    assert_busy_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wip) |-> (busy_len == TPP_CYCLES));

    assert_wel_clear_in_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wel) |-> wip);

    assert_needs_wel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wip) |-> $past(wel));

endmodule

bind dual_page_prog dpp_checker #(
    .ADDR_W     (ADDR_W),
    .OFF_W      (OFF_W),
    .TPP_CYCLES (TPP_CYCLES)
) u_dpp_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .wip      (wip),
    .wel      (wel),
    .arr_we   (arr_we),
    .arr_addr (arr_addr)
);

// File: tb/dual_page_prog_bench.sv
// Bench: behavioural per-clock model of status and array strobes for
// dual_page_prog, with directed frames for each requirement.
module dual_page_prog_bench;

    localparam int TPP = 600;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic        dq0 = 1'b0;
    logic        dq1 = 1'b0;
    logic        wel_set = 1'b0;
    logic [2:0]  bp_level = 3'd0;
    logic        wip;
    logic        wel;
    logic        arr_we;
    logic [23:0] arr_addr;
    logic [7:0]  arr_wdata;

    always #5 clk = ~clk;

    dual_page_prog #(.TPP_CYCLES(TPP)) u_dual_page_prog (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq0(dq0), .dq1(dq1),
        .wel_set(wel_set), .bp_level(bp_level), .wip(wip), .wel(wel),
        .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Model state
    logic [7:0] exp_buf [256];
    bit         exp_flag [256];
    logic [15:0] exp_page;
    int  busy_left = 0;
    bit  exp_wel = 0;
    bit  commit_pending = 0;
    bit  wel_pending = 0;
    int  strobes = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model
    always begin
        @(posedge clk);
        #2;
        if (rst_n && !done) begin
            int idx;
            bit ewe;
            if (commit_pending) begin
                busy_left = TPP;
                commit_pending = 0;
            end
            if (wel_pending) begin
                exp_wel = 1;
                wel_pending = 0;
            end
            idx = TPP - busy_left;
            if (busy_left > 0 && idx == 257) exp_wel = 0;
            ewe = (busy_left > 0) && (idx < 256) && exp_flag[idx < 256 ? idx : 0];
            check(wip == (busy_left > 0), "R7 wip", int'(wip), int'(busy_left > 0));
            check(wel == exp_wel, "R8 R12 wel", int'(wel), int'(exp_wel));
            check(arr_we == ewe, "R5 arr_we", int'(arr_we), int'(ewe));
            if (ewe && arr_we) begin
                check(arr_addr == {exp_page, idx[7:0]}, "R3 arr_addr", int'(arr_addr), int'({exp_page, idx[7:0]}));
                check(arr_wdata == exp_buf[idx], "R2 R4 arr_wdata", int'(arr_wdata), int'(exp_buf[idx]));
            end
            if (arr_we) strobes++;
            if (busy_left > 0) busy_left--;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic edge_out(input bit hi, input bit lo);
        dq1 = hi;
        dq0 = lo;
        tick(3);
        sck = 1'b1;
        tick(3);
        sck = 1'b0;
    endtask

    task automatic pulse_wel();
        @(negedge clk);
        wel_set = 1'b1;
        wel_pending = 1;
        @(negedge clk);
        wel_set = 1'b0;
        tick(2);
    endtask

    function automatic bit is_prot(input logic [2:0] bp, input logic [15:0] pg);
        int m;
        if (bp == 3'd0) return 0;
        m = 7 - int'(bp);
        if (m == 0) return 1;
        return (int'(pg) >> (16 - m)) == ((1 << m) - 1);
    endfunction

    function automatic logic [7:0] dbyte(input int base, input int i);
        return 8'((base + i * 37) & 8'hFF);
    endfunction

    // One frame; returns whether the model expects a commit
    task automatic send_frame(input logic [7:0] op, input logic [23:0] addr, input int nbytes,
                              input int extra_pairs, input int base, output bit committed);
        logic [7:0] lbuf [256];
        bit         lflag [256];
        bit         busy_at_fall;
        bit         wel_at_op;
        for (int i = 0; i < 256; i++) begin lbuf[i] = 8'h00; lflag[i] = 0; end
        @(negedge clk);
        cs_n = 1'b0;
        busy_at_fall = (busy_left > 0);
        tick(2);
        for (int b = 7; b >= 0; b--) edge_out(1'b0, op[b]);
        wel_at_op = exp_wel;
        for (int b = 23; b >= 0; b--) edge_out(1'b0, addr[b]);
        for (int i = 0; i < nbytes; i++) begin
            logic [7:0] d;
            int off;
            d = dbyte(base, i);
            for (int p = 3; p >= 0; p--) edge_out(d[2*p+1], d[2*p]);
            off = (int'(addr[7:0]) + i) % 256;
            lbuf[off] = d;
            lflag[off] = 1;
        end
        for (int p = 0; p < extra_pairs; p++) edge_out(1'b1, 1'b0);
        committed = !busy_at_fall && wel_at_op && (op == 8'hA2) && (nbytes >= 1) &&
                    (extra_pairs == 0) && !is_prot(bp_level, addr[23:8]);
        tick(2);
        if (committed) begin
            for (int i = 0; i < 256; i++) begin exp_buf[i] = lbuf[i]; exp_flag[i] = lflag[i]; end
            exp_page = addr[23:8];
            commit_pending = 1;
        end
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic wait_idle();
        tick(2);
        while (busy_left > 0) @(negedge clk);
        tick(3);
    endtask

    function automatic int count_flags();
        int c = 0;
        for (int i = 0; i < 256; i++) if (exp_flag[i]) c++;
        return c;
    endfunction

    // Directed frame plus strobe-count and status checks
    task automatic run_case(input string tag, input logic [7:0] op, input logic [23:0] addr,
                            input int nbytes, input int extra, input int base, input bit want_commit);
        bit c;
        int s0;
        bit wel0;
        s0 = strobes;
        wel0 = exp_wel;
        send_frame(op, addr, nbytes, extra, base, c);
        check(c == want_commit, {tag, " commit decision"}, int'(c), int'(want_commit));
        tick(1);
        check(wip == want_commit, {tag, " wip after cs rise"}, int'(wip), int'(want_commit));
        wait_idle();
        check(strobes - s0 == (want_commit ? count_flags() : 0), {tag, " strobe count"},
              strobes - s0, want_commit ? count_flags() : 0);
        if (!want_commit) check(wel == wel0, {tag, " R12 wel kept"}, int'(wel), int'(wel0));
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin exp_buf[i] = 8'h00; exp_flag[i] = 0; end
        exp_page = 16'h0;
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check(wip == 1'b0 && wel == 1'b0 && arr_we == 1'b0, "R1 reset state",
              int'({wip, wel, arr_we}), 0);

        // R2 R5: short program mid-page
        pulse_wel();
        run_case("R2 R5 short", 8'hA2, 24'h0012_10, 3, 0, 5, 1);
        check(wel == 1'b0, "R8 wel after cycle", int'(wel), 0);

        // R3: wrap inside the page
        pulse_wel();
        run_case("R3 wrap", 8'hA2, 24'h0345_FE, 4, 0, 9, 1);

        // R4: more than a page of bytes
        pulse_wel();
        run_case("R4 overlong", 8'hA2, 24'h0777_00, 260, 0, 1, 1);

        // R9: no write-enable latch, then wrong opcode
        run_case("R9 no wel", 8'hA2, 24'h0012_00, 2, 0, 3, 0);
        pulse_wel();
        run_case("R9 wrong opcode", 8'h02, 24'h0012_00, 2, 0, 3, 0);

        // R6: misaligned rise and zero data bytes
        run_case("R6 misaligned", 8'hA2, 24'h0012_00, 2, 1, 3, 0);
        run_case("R6 no data", 8'hA2, 24'h0012_00, 0, 0, 3, 0);

        // R10: protected top page, then unprotected page at same level
        bp_level = 3'd1;
        run_case("R10 protected", 8'hA2, 24'hFFFF_20, 2, 0, 7, 0);
        bp_level = 3'd7;
        run_case("R10 all protected", 8'hA2, 24'h0001_00, 1, 0, 7, 0);
        bp_level = 3'd1;
        run_case("R10 open page", 8'hA2, 24'h0012_20, 2, 0, 7, 1);
        bp_level = 3'd0;

        // R11: valid frame sent while busy is ignored
        begin
            bit c;
            int s0;
            pulse_wel();
            send_frame(8'hA2, 24'h0100_00, 1, 0, 11, c);
            check(c == 1'b1, "R11 first commit", int'(c), 1);
            while (TPP - busy_left < 262) @(negedge clk);
            pulse_wel();
            s0 = strobes;
            send_frame(8'hA2, 24'h0200_00, 1, 0, 13, c);
            check(c == 1'b0, "R11 busy frame decision", int'(c), 0);
            check(busy_left > 0, "R11 frame ended inside cycle", busy_left, 1);
            wait_idle();
            check(strobes == s0, "R11 no strobes from busy frame", strobes - s0, 0);
            check(wel == 1'b1, "R11 R12 wel kept after ignored frame", int'(wel), 1);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog
    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule